// File: doc/BRIEF.md
# Collision-Vector Issue Controller

This block guards the entry of a multi-stage pipeline whose stages are used more than once by each operation. Every cycle it decides whether a waiting operation may start without two operations ever needing the same stage in the same cycle. The set of forbidden start-to-start distances is fixed at elaboration by a collision-vector parameter. Bit i of that vector stands for a distance of i+1 cycles, so bit 0 is a distance of one cycle. A 1 marks a forbidden distance. Any distance longer than the vector is always safe.

The controller keeps a collision-state register. The register moves one position toward bit 0 every cycle. When an operation starts, the register also takes in the collision vector by a bitwise OR. A request is granted in the same cycle whenever the bit for the current distance is clear. By default the policy is greedy, so every free slot is taken. An optional fixed mode only allows one constant spacing between starts, plus restarts after a long pause. At elaboration the block checks that this spacing is collision-free.

Two free-running counters expose the number of grants and the number of elapsed cycles. Dividing the cycles by the grants gives the average initiation latency, which can be compared against the expected greedy cycle.

Top module: `cv_issue_ctrl`

## Requirements
- R1: While rst_n is low, grant_o is 0, state_o is all zeros, and both counters read 0. The first request after reset is granted in the cycle it is presented.
- R2: grant_o is high only in a cycle where req_i is high and state_o bit 0 is 0. It is a combinational response within that cycle.
- R3: Bit i of the parameter CV marks latency i+1 as forbidden (bit 0 is latency 1). On a clock edge where grant_o is high, state_o becomes (state_o >> 1) | CV.
- R4: On a clock edge where grant_o is low, state_o shifts right by one position with a 0 entering at the top bit.
- R5: In greedy mode (MODE_GREEDY), every cycle with req_i high and state_o bit 0 equal to 0 is granted. With the request held high from reset, the start spacings repeat as follows:
  - CV=5'b11100 gives (1,1,6), an average of 8/3.
  - CV=3'b100 gives (1,1,4), an average of 2.
  - CV=5'b10011 gives a constant 3.
- R6: grant_cnt_o rises by exactly one on each edge where grant_o is high and holds otherwise. cycle_cnt_o rises by one on every edge out of reset.
- R7: After more than CV_W cycles without a grant, state_o is all zeros and a request is granted at once.
- R8: Over a steady-request run from reset, cycle_cnt_o is at most grant_cnt_o multiplied by (number of 1s in CV, plus 1).
- R9: In fixed mode (MODE_FIXED), a grant additionally requires one of the following:
  - the cycles since the last grant equal FIXED_LAT;
  - the cycles since the last grant exceed CV_W;
  - no grant has happened since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | An operation is waiting to enter the pipeline |
| grant_o | output | 1 | The waiting operation starts this cycle |
| state_o | output | CV_W | Collision state; bit 0 is the distance being offered this cycle |
| grant_cnt_o | output | CNT_W | Number of grants since reset |
| cycle_cnt_o | output | CNT_W | Number of cycles since reset |

## Verification
Two updates can land on the same edge: a new start ORs the collision vector into the register while the older reservations are still shifting down by one. The vector table for CV=11100 grants back to back while earlier reservations are still in flight. State 11110 must become exactly 11111 there, with the overlapping bits merged rather than lost or doubled. A second collision is a request that arrives in the very cycle the register has drained to zero. This is provoked with long request pauses and judged by exact grant timing in greedy and fixed modes alike.

// File: rtl/cv_issue_pkg.sv
package cv_issue_pkg;

    // Issue policy selector.
    typedef enum logic {
        MODE_GREEDY = 1'b0,
        MODE_FIXED  = 1'b1
    } issue_mode_e;

    // Widest collision vector the helper functions accept.
    localparam int VEC_MAX = 32;

    // True when a constant start spacing of lat never hits a forbidden distance.
    function automatic bit const_lat_ok(input logic [VEC_MAX-1:0] cv,
                                        input int width,
                                        input int lat);
        bit ok;
        ok = (lat > 0);
        for (int m = 1; m <= VEC_MAX; m++) begin
            if (lat > 0 && m <= width && (m % lat) == 0 && cv[m-1]) begin
                ok = 1'b0;
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/cv_issue_gate.sv
module cv_issue_gate
    import cv_issue_pkg::*;
#(
    parameter int              CV_W      = 5,
    parameter logic [CV_W-1:0] CV        = 5'b11100,
    parameter issue_mode_e     MODE      = MODE_GREEDY,
    parameter int              FIXED_LAT = 6,
    parameter int              GAP_W     = 3
) (
    input  logic             rst_n,
    input  logic             req,
    input  logic             slot_busy,
    input  logic [GAP_W-1:0] gap,
    output logic             grant
);

    localparam int GAP_SAT  = CV_W + 1;
    localparam int LAT_EFF  = (FIXED_LAT > CV_W) ? GAP_SAT : FIXED_LAT;
    localparam bit IS_FIXED = (MODE == MODE_FIXED);

    logic spacing_ok;
    logic mode_ok;

    // Fixed spacing: exactly the chosen distance, or a pause long enough to be idle.
    assign spacing_ok = (gap == GAP_W'(LAT_EFF)) || (gap == GAP_W'(GAP_SAT));
    assign mode_ok    = !IS_FIXED || spacing_ok;

    generate
        if (IS_FIXED) begin : g_fixed_check
            if (!const_lat_ok(VEC_MAX'(CV), CV_W, FIXED_LAT)) begin : g_bad_lat
                $error("cv_issue_gate: constant latency %0d collides with vector %b",
                       FIXED_LAT, CV);
            end
        end
    endgenerate

    assign grant = rst_n && req && !slot_busy && mode_ok;

endmodule

// File: rtl/cv_event_counter.sv
module cv_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/cv_issue_ctrl.sv
module cv_issue_ctrl
    import cv_issue_pkg::*;
#(
    parameter int              CV_W      = 5,
    parameter logic [CV_W-1:0] CV        = 5'b11100,
    parameter issue_mode_e     MODE      = MODE_GREEDY,
    parameter int              FIXED_LAT = 6,
    parameter int              CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    output logic             grant_o,
    output logic [CV_W-1:0]  state_o,
    output logic [CNT_W-1:0] grant_cnt_o,
    output logic [CNT_W-1:0] cycle_cnt_o
);

    localparam int GAP_SAT = CV_W + 1;
    localparam int GAP_W   = $clog2(CV_W + 2);

    typedef struct packed {
        logic [CV_W-1:0]  coll;
        logic [GAP_W-1:0] gap;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;
    logic grant;

    cv_issue_gate #(
        .CV_W      (CV_W),
        .CV        (CV),
        .MODE      (MODE),
        .FIXED_LAT (FIXED_LAT),
        .GAP_W     (GAP_W)
    ) u_gate (
        .rst_n     (rst_n),
        .req       (req_i),
        .slot_busy (ctl_q.coll[0]),
        .gap       (ctl_q.gap),
        .grant     (grant)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (grant) begin
            ctl_d.coll = (ctl_q.coll >> 1) | CV;
            ctl_d.gap  = GAP_W'(1);
        end else begin
            ctl_d.coll = ctl_q.coll >> 1;
            if (ctl_q.gap != GAP_W'(GAP_SAT)) begin
                ctl_d.gap = ctl_q.gap + GAP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.coll <= '0;
            ctl_q.gap  <= GAP_W'(GAP_SAT);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    cv_event_counter #(.CNT_W(CNT_W)) u_grant_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (grant),
        .count_o (grant_cnt_o)
    );

    cv_event_counter #(.CNT_W(CNT_W)) u_cycle_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (1'b1),
        .count_o (cycle_cnt_o)
    );

    assign grant_o = grant;
    assign state_o = ctl_q.coll;

endmodule

// File: rtl/cv_issue_ctrl_chk.sv
module cv_issue_ctrl_chk
    import cv_issue_pkg::*;
#(
    parameter int              CV_W      = 5,
    parameter logic [CV_W-1:0] CV        = 5'b11100,
    parameter issue_mode_e     MODE      = MODE_GREEDY,
    parameter int              FIXED_LAT = 6,
    parameter int              CNT_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic             grant_o,
    input logic [CV_W-1:0]  state_o,
    input logic [CNT_W-1:0] grant_cnt_o,
    input logic [CNT_W-1:0] cycle_cnt_o
);

    localparam int GAP_SAT = CV_W + 1;
    localparam int GAP_W   = $clog2(CV_W + 2);
    localparam int LAT_EFF = (FIXED_LAT > CV_W) ? GAP_SAT : FIXED_LAT;

    // Independent count of cycles since the last grant.
    logic [GAP_W-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= GAP_W'(GAP_SAT);
        end else if (grant_o) begin
            since_q <= GAP_W'(1);
        end else if (since_q != GAP_W'(GAP_SAT)) begin
            since_q <= since_q + GAP_W'(1);
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!grant_o && state_o == '0 && grant_cnt_o == '0 && cycle_cnt_o == '0));

    assert_grant_needs_free_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (req_i && !state_o[0]));

    assert_merge_on_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |=> (state_o == (($past(state_o) >> 1) | CV)));

    assert_shift_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_o |=> (state_o == ($past(state_o) >> 1)));

    assert_greedy_takes_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_GREEDY && req_i && !state_o[0]) |-> grant_o);

    assert_grant_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |=> (grant_cnt_o == $past(grant_cnt_o) + CNT_W'(1)));

    assert_grant_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_o |=> $stable(grant_cnt_o));

    assert_cycle_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cycle_cnt_o == $past(cycle_cnt_o) + CNT_W'(1)));

    assert_idle_after_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == GAP_W'(GAP_SAT)) |-> (state_o == '0));

    assert_fixed_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_FIXED && grant_o) |->
            (since_q == GAP_W'(LAT_EFF) || since_q == GAP_W'(GAP_SAT)));

endmodule

bind cv_issue_ctrl cv_issue_ctrl_chk #(
    .CV_W      (CV_W),
    .CV        (CV),
    .MODE      (MODE),
    .FIXED_LAT (FIXED_LAT),
    .CNT_W     (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .grant_o     (grant_o),
    .state_o     (state_o),
    .grant_cnt_o (grant_cnt_o),
    .cycle_cnt_o (cycle_cnt_o)
);

// File: tb/cv_issue_ctrl_bench.sv
`timescale 1ns/1ps
module cv_issue_ctrl_bench;
    import cv_issue_pkg::*;

    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_a = 1'b0, req_b = 1'b0, req_c = 1'b0, req_d = 1'b0;
    logic gnt_a, gnt_b, gnt_c, gnt_d;
    logic [4:0] st_a, st_c;
    logic [2:0] st_b, st_d;
    logic [CNT_W-1:0] gc_a, gc_b, gc_c, gc_d;
    logic [CNT_W-1:0] cc_a, cc_b, cc_c, cc_d;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // Instance A: defaults, CV=11100, greedy.
    cv_issue_ctrl u_cv_issue_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_a), .grant_o(gnt_a),
        .state_o(st_a), .grant_cnt_o(gc_a), .cycle_cnt_o(cc_a));

    cv_issue_ctrl #(.CV_W(3), .CV(3'b100)) u_cv_issue_ctrl_b (
        .clk(clk), .rst_n(rst_n), .req_i(req_b), .grant_o(gnt_b),
        .state_o(st_b), .grant_cnt_o(gc_b), .cycle_cnt_o(cc_b));

    cv_issue_ctrl #(.CV_W(5), .CV(5'b10011)) u_cv_issue_ctrl_c (
        .clk(clk), .rst_n(rst_n), .req_i(req_c), .grant_o(gnt_c),
        .state_o(st_c), .grant_cnt_o(gc_c), .cycle_cnt_o(cc_c));

    cv_issue_ctrl #(.CV_W(3), .CV(3'b100), .MODE(MODE_FIXED), .FIXED_LAT(2)) u_cv_issue_ctrl_d (
        .clk(clk), .rst_n(rst_n), .req_i(req_d), .grant_o(gnt_d),
        .state_o(st_d), .grant_cnt_o(gc_d), .cycle_cnt_o(cc_d));

    // {req, expected grant, expected state} for instance A, one row per cycle.
    localparam logic [6:0] VEC [16] = '{
        7'b1_1_00000, 7'b1_1_11100, 7'b0_0_11110, 7'b1_0_01111,
        7'b1_0_00111, 7'b1_0_00011, 7'b1_0_00001, 7'b1_1_00000,
        7'b1_1_11100, 7'b1_1_11110, 7'b1_0_11111, 7'b0_0_01111,
        7'b1_0_00111, 7'b0_0_00011, 7'b0_0_00001, 7'b1_1_00000
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_a = 1'b0; req_b = 1'b0; req_c = 1'b0; req_d = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: values held during reset, even with a request present.
        repeat (3) @(negedge clk);
        req_a = 1'b1;
        #1;
        check("R1 grant in reset", 32'(gnt_a), 32'd0);
        check("R1 state in reset", 32'(st_a), 32'd0);
        check("R1 grant count in reset", 32'(gc_a), 32'd0);
        check("R1 cycle count in reset", 32'(cc_a), 32'd0);
        req_a = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Vector walk on instance A.
        for (int i = 0; i < 16; i++) begin
            logic prev_g;
            prev_g = (i > 0) ? VEC[i-1][5] : 1'b0;
            req_a = VEC[i][6];
            #1;
            check($sformatf("R2 grant row %0d", i), 32'(gnt_a), 32'(VEC[i][5]));
            check($sformatf("%s state row %0d", prev_g ? "R3" : "R4", i),
                  32'(st_a), 32'(VEC[i][4:0]));
            @(negedge clk);
        end
        req_a = 1'b0;
        #1;
        check("R3 state after final grant", 32'(st_a), 32'h1c);
        check("R6 grant count after table", 32'(gc_a), 32'd6);
        check("R6 cycle count after table", 32'(cc_a), 32'd16);

        // R1: mid-run reset clears a busy state.
        @(negedge clk);
        rst_n = 1'b0;
        req_a = 1'b1;
        #1;
        check("R1 state cleared by reset", 32'(st_a), 32'd0);
        check("R1 grant held low in reset", 32'(gnt_a), 32'd0);
        check("R1 counter cleared by reset", 32'(gc_a), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Steady request on all instances from reset.
        req_a = 1'b1; req_b = 1'b1; req_c = 1'b1; req_d = 1'b1;
        for (int k = 0; k < 24; k++) begin
            #1;
            check($sformatf("R5 greedy 11100 cycle %0d", k), 32'(gnt_a), 32'((k % 8) < 3));
            check($sformatf("R5 greedy 100 cycle %0d", k), 32'(gnt_b), 32'((k % 6) < 3));
            check($sformatf("R5 greedy 10011 cycle %0d", k), 32'(gnt_c), 32'((k % 3) == 0));
            check($sformatf("R9 fixed 2 cycle %0d", k), 32'(gnt_d), 32'((k % 2) == 0));
            @(negedge clk);
        end
        #1;
        check("R6 grant count 11100", 32'(gc_a), 32'd9);
        check("R6 cycle count 11100", 32'(cc_a), 32'd24);
        check("R6 grant count 100", 32'(gc_b), 32'd12);
        check("R6 grant count 10011", 32'(gc_c), 32'd8);
        check("R9 grant count fixed", 32'(gc_d), 32'd12);
        check("R5 average 8/3", 32'(cc_a) * 3, 32'(gc_a) * 8);
        check("R5 average 2", 32'(cc_b), 32'(gc_b) * 2);
        check("R5 average 3", 32'(cc_c), 32'(gc_c) * 3);
        check("R8 bound 11100", 32'(32'(cc_a) <= 32'(gc_a) * 4), 32'd1);
        check("R8 bound 100", 32'(32'(cc_b) <= 32'(gc_b) * 2), 32'd1);
        check("R8 bound 10011", 32'(32'(cc_c) <= 32'(gc_c) * 4), 32'd1);

        // R7 / R9: long pauses on A (greedy) and D (fixed).
        do_reset();
        for (int k = 0; k < 7; k++) begin
            req_a = (k == 0 || k == 6);
            req_d = (k == 0 || k == 4);
            #1;
            check($sformatf("R9 fixed after pause cycle %0d", k), 32'(gnt_d),
                  32'(k == 0 || k == 4));
            if (k == 6) begin
                check("R7 state drained after pause", 32'(st_a), 32'd0);
                check("R7 grant after pause", 32'(gnt_a), 32'd1);
            end
            @(negedge clk);
        end
        req_a = 1'b0; req_d = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule